// File: doc/BRIEF.md
# Minimal Byte-Wide Fetch/Execute Core

This block is a very small processor core with a 16-bit address bus and an 8-bit read-only data path. It knows two instructions: a one-byte no-operation and a three-byte absolute jump. Every instruction fetch is a burst of three reads: the opcode at the program counter and the two bytes after it. The two extra bytes are read even when the opcode turns out not to need them. Once the last byte has arrived, the core sits in a fixed execution delay. Then it either moves the program counter forward by one byte or loads it with the jump target, and starts the next burst.

The memory behind the bus must be synchronous with a latency of one cycle. It updates its read data only on clock edges where the read strobe is high, and the core samples that data one cycle after it drove the address. Because of this contract, a halt input can freeze the core at any point, even in the middle of a burst, without losing a byte.

The core is sized by parameters: the address width, the data width, the jump opcode, the execution delay and the operand byte order. The defaults are 16-bit addresses, 8-bit data, jump opcode 0x7E, a delay of 8 cycles and the high byte first.

Top module: `byte_fetch_core`

## Requirements
- R1: While `rst` is high, `mem_rd` is 0 and `mem_addr` is 0x0000. At the first rising edge with `rst` low, the core leaves idle. In the cycle after that edge it drives address 0x0000 with `mem_rd` high. A reset in the middle of an instruction returns the core to this behaviour.
- R2: A fetch burst lasts three consecutive strobe cycles (`mem_rd` = 1). The addresses in those cycles are PC, PC+1 and PC+2.
- R3: The core captures `mem_rdata` at the end of the cycle after the one in which it drove the matching address. The memory changes `mem_rdata` only on edges where `mem_rd` is high.
- R4: Opcode 0x01 is a no-op. The next burst starts at PC+1.
- R5: Opcode 0x7E is a jump. The next burst starts at {byte at PC+1, byte at PC+2}: the byte at PC+1 is the high byte and the byte at PC+2 is the low byte.
- R6: Any opcode other than 0x01 and 0x7E behaves like the no-op. The next burst starts at PC+1.
- R7: When halt stays low, a burst is followed by exactly 1+EXEC_WAIT cycles with `mem_rd` low (one capture cycle plus the delay). Bursts therefore start every 4+EXEC_WAIT cycles. Outside a burst, `mem_addr` shows the PC of the current instruction.
- R8: In every cycle with `halt` high, `mem_rd` is 0 and no state moves, so `mem_addr` holds. After `halt` falls, the core resumes from where it stopped. The cycles spent halted add directly to the timing.
- R9: All address arithmetic wraps modulo 2^16. A burst at 0xFFFF reads 0xFFFF, 0x0000, 0x0001, and a no-op at 0xFFFF continues at 0x0000.
- R10: With a no-op at address 0 and a jump to 0x0000 at address 1, the bursts start at 0, 1, 0, 1, ... without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the core while high |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe, high only in the cycles of a fetch burst |
| mem_rdata | input | 8 | Read data, valid in the cycle after its address |

## Verification
A corrupted program counter shows up at the start of the next burst as a wrong `mem_addr`. That is at most 4+EXEC_WAIT cycles after the decision. A byte captured into the wrong slot shows up in the same place as a wrong jump target or as a wrong choice between jump and step. A sequencer that is one count off shows up within one instruction period: the strobe is too long, too short, or arrives early or late, and the spacing of the bursts shifts. A halt that leaks state shows up as an address that moves, or a strobe that rises, during the halted cycles themselves. After the halt it also shows up as a wrong byte in the resumed burst.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

   // Sequencer phases of one instruction.
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FETCH = 2'd1,
      SEQ_TAIL  = 2'd2,
      SEQ_WAIT  = 2'd3
   } seq_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bfc_fetch_seq.sv
module bfc_fetch_seq
   import bfc_pkg::*;
#(
   parameter int unsigned N_BYTES   = 3,
   parameter int unsigned EXEC_WAIT = 8,
   localparam int unsigned IDX_W    = idx_width(N_BYTES),
   localparam int unsigned WAIT_W   = (EXEC_WAIT > 1) ? $clog2(EXEC_WAIT) : 1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             halt,
   output logic             rd_en,
   output logic [IDX_W-1:0] offset,
   output logic             cap_en,
   output logic [IDX_W-1:0] cap_slot,
   output logic             exec_done
);

   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_BYTES - 1);
   localparam logic [WAIT_W-1:0] LAST_WAIT = WAIT_W'(EXEC_WAIT - 1);

   seq_state_t        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WAIT_W-1:0] wcnt_q;

   always_comb begin
      rd_en     = (state_q == SEQ_FETCH) && !halt;
      offset    = (state_q == SEQ_FETCH) ? idx_q : '0;
      cap_en    = !halt && (((state_q == SEQ_FETCH) && (idx_q != '0)) ||
                            (state_q == SEQ_TAIL));
      cap_slot  = (state_q == SEQ_TAIL) ? LAST_IDX : (idx_q - 1'b1);
      exec_done = !halt && (state_q == SEQ_WAIT) && (wcnt_q == LAST_WAIT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         wcnt_q  <= '0;
      end else if (!halt) begin
         unique case (state_q)
            SEQ_IDLE: begin
               state_q <= SEQ_FETCH;
               idx_q   <= '0;
            end
            SEQ_FETCH: begin
               if (idx_q == LAST_IDX) begin
                  state_q <= SEQ_TAIL;
                  idx_q   <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            SEQ_TAIL: begin
               state_q <= SEQ_WAIT;
               wcnt_q  <= '0;
            end
            SEQ_WAIT: begin
               if (wcnt_q == LAST_WAIT) begin
                  state_q <= SEQ_FETCH;
                  idx_q   <= '0;
                  wcnt_q  <= '0;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bfc_operand_capture.sv
module bfc_operand_capture
   import bfc_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned N_BYTES = 3,
   localparam int unsigned IDX_W  = idx_width(N_BYTES),
   localparam int unsigned OPND_W = (N_BYTES - 1) * DATA_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_en,
   input  logic [IDX_W-1:0]  cap_slot,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] opcode,
   output logic [OPND_W-1:0] opnd_flat
);

   for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
      logic [DATA_W-1:0] q;

      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (cap_en && (cap_slot == IDX_W'(g))) begin
            q <= rd_data;
         end
      end

      if (g == 0) begin : g_op
         assign opcode = q;
      end else begin : g_opnd
         assign opnd_flat[(g-1)*DATA_W +: DATA_W] = q;
      end
   end

endmodule

// File: rtl/bfc_op_decode.sv
module bfc_op_decode #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned OP_JMP     = 'h7E,
   parameter bit          HIGH_FIRST = 1'b1,
   localparam int unsigned N_OPND    = ADDR_W / DATA_W
)(
   input  logic [DATA_W-1:0]        opcode,
   input  logic [N_OPND*DATA_W-1:0] opnd_flat,
   output logic                     is_jmp,
   output logic [ADDR_W-1:0]        target
);

   // Every opcode that is not the jump steps forward like the no-op.
   assign is_jmp = (opcode == DATA_W'(OP_JMP));

   for (genvar k = 0; k < N_OPND; k++) begin : g_assemble
      if (HIGH_FIRST) begin : g_hi
         assign target[(N_OPND-1-k)*DATA_W +: DATA_W] = opnd_flat[k*DATA_W +: DATA_W];
      end else begin : g_lo
         assign target[k*DATA_W +: DATA_W] = opnd_flat[k*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/bfc_pc_unit.sv
module bfc_pc_unit #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 2
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              exec_done,
   input  logic              is_jmp,
   input  logic [ADDR_W-1:0] target,
   input  logic [IDX_W-1:0]  offset,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else if (exec_done) begin
         pc_q <= is_jmp ? target : (pc_q + 1'b1);
      end
   end

   // Wraps at the top of the address space.
   assign addr = pc_q + ADDR_W'(offset);

endmodule

// File: rtl/byte_fetch_core.sv
module byte_fetch_core
   import bfc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned EXEC_WAIT  = 8,
   parameter int unsigned OP_JMP     = 'h7E,
   parameter bit          HIGH_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              halt,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int unsigned N_OPND  = ADDR_W / DATA_W;
   localparam int unsigned N_BYTES = N_OPND + 1;
   localparam int unsigned IDX_W   = idx_width(N_BYTES);

   if (DATA_W < 1 || ADDR_W < DATA_W || (ADDR_W % DATA_W) != 0) begin : g_bad_width
      $error("byte_fetch_core: ADDR_W must be a nonzero multiple of DATA_W");
   end
   if (EXEC_WAIT < 1) begin : g_bad_wait
      $error("byte_fetch_core: EXEC_WAIT must be at least 1");
   end
   if (DATA_W < 32 && OP_JMP >= (32'd1 << DATA_W)) begin : g_bad_op
      $error("byte_fetch_core: OP_JMP does not fit in DATA_W");
   end

   logic                     cap_en;
   logic [IDX_W-1:0]         cap_slot;
   logic [IDX_W-1:0]         offset;
   logic                     exec_done;
   logic [DATA_W-1:0]        opcode;
   logic [N_OPND*DATA_W-1:0] opnd_flat;
   logic                     is_jmp;
   logic [ADDR_W-1:0]        target;

   bfc_fetch_seq #(
      .N_BYTES   (N_BYTES),
      .EXEC_WAIT (EXEC_WAIT)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .halt      (halt),
      .rd_en     (mem_rd),
      .offset    (offset),
      .cap_en    (cap_en),
      .cap_slot  (cap_slot),
      .exec_done (exec_done)
   );

   bfc_operand_capture #(
      .DATA_W  (DATA_W),
      .N_BYTES (N_BYTES)
   ) u_cap (
      .clk       (clk),
      .rst       (rst),
      .cap_en    (cap_en),
      .cap_slot  (cap_slot),
      .rd_data   (mem_rdata),
      .opcode    (opcode),
      .opnd_flat (opnd_flat)
   );

   bfc_op_decode #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .OP_JMP     (OP_JMP),
      .HIGH_FIRST (HIGH_FIRST)
   ) u_dec (
      .opcode    (opcode),
      .opnd_flat (opnd_flat),
      .is_jmp    (is_jmp),
      .target    (target)
   );

   bfc_pc_unit #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_pc (
      .clk       (clk),
      .rst       (rst),
      .exec_done (exec_done),
      .is_jmp    (is_jmp),
      .target    (target),
      .offset    (offset),
      .addr      (mem_addr)
   );

endmodule

// File: rtl/byte_fetch_core_chk.sv
module byte_fetch_core_chk #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned EXEC_WAIT = 8
)(
   input logic              clk,
   input logic              rst,
   input logic              halt,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr
);

   localparam int unsigned GW = $clog2(EXEC_WAIT + 3) + 1;
   localparam logic [GW-1:0] GAP_EXP = GW'(EXEC_WAIT + 1);
   localparam logic [GW-1:0] GAP_MAX = {GW{1'b1}};

   // Counts unhalted strobe-low cycles since the last strobe.
   logic [GW-1:0] gap_q;
   logic          seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (!halt) begin
         if (mem_rd) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
         end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!mem_rd && (mem_addr == '0)));

   assert_burst_step_R2: assert property (@(posedge clk) disable iff (rst)
      mem_rd |=> (!mem_rd || (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))));

   assert_gap_length_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && seen_q && (gap_q != '0)) |-> (gap_q == GAP_EXP));

   assert_halt_no_read_R8: assert property (@(posedge clk) disable iff (rst)
      halt |-> !mem_rd);

   assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(halt) && !$past(rst)) |-> (mem_addr == $past(mem_addr)));

endmodule

bind byte_fetch_core byte_fetch_core_chk #(
   .ADDR_W    (ADDR_W),
   .EXEC_WAIT (EXEC_WAIT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .halt     (halt),
   .mem_rd   (mem_rd),
   .mem_addr (mem_addr)
);

// File: tb/test_byte_fetch_core.sv
`timescale 1ns/1ps
module test_byte_fetch_core;

   localparam int EW = 8;
   localparam int WD_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        halt = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata = 8'h00;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   byte_fetch_core #(.EXEC_WAIT(EW)) i_byte_fetch_core (
      .clk       (clk),
      .rst       (rst),
      .halt      (halt),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_rdata (mem_rdata)
   );

   // Behavioural ROM: sparse table, unlisted bytes read 0xFF.
   logic [15:0] pa [8];
   logic [7:0]  pd [8];
   int          pn = 0;

   function automatic logic [7:0] rom(input logic [15:0] a);
      logic [7:0] v = 8'hFF;
      for (int i = 0; i < pn; i++) if (pa[i] == a) v = pd[i];
      return v;
   endfunction

   always @(posedge clk) if (mem_rd) mem_rdata <= rom(mem_addr);

   task automatic put(input int i, input logic [15:0] a, input logic [7:0] d);
      pa[i] = a; pd[i] = d;
      if (i + 1 > pn) pn = i + 1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT && !done) begin
         fails = fails + 1;
         $display("FAIL watchdog R7 actual_cycles=%0d expected_max=%0d", cyc, WD_LIMIT);
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic fetch3(input logic [15:0] pc, input string tag);
      for (int k = 0; k < 3; k++) begin
         logic [15:0] e = pc + 16'(k);
         chk({tag, " R2 strobe"}, 32'(mem_rd), 32'd1);
         chk({tag, " R2 R9 addr"}, 32'(mem_addr), 32'(e));
         step();
      end
   endtask

   task automatic gap(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         chk({tag, " R7 gap strobe"}, 32'(mem_rd), 32'd0);
         step();
      end
   endtask

   task automatic burst(input logic [15:0] pc, input string tag);
      fetch3(pc, tag);
      gap(1 + EW, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; halt = 1'b0;
      step(); step();
      chk("R1 reset strobe", 32'(mem_rd), 32'd0);
      chk("R1 reset addr", 32'(mem_addr), 32'd0);
      rst = 1'b0;
      step();
   endtask

   task automatic load_loop();
      pn = 0;
      put(0, 16'h0000, 8'h01);
      put(1, 16'h0001, 8'h7E);
      put(2, 16'h0002, 8'h00);
      put(3, 16'h0003, 8'h00);
   endtask

   task automatic t_loop();
      load_loop();
      do_reset();
      burst(16'h0000, "R10 R4 nop");
      burst(16'h0001, "R10 R5 jmp");
      burst(16'h0000, "R10 again");
      burst(16'h0001, "R10 again");
   endtask

   task automatic t_far();
      pn = 0;
      put(0, 16'h0000, 8'h7E);
      put(1, 16'h0001, 8'h12);
      put(2, 16'h0002, 8'h34);
      put(3, 16'h1234, 8'h01);
      do_reset();
      burst(16'h0000, "R5 jmp");
      burst(16'h1234, "R5 high byte first");
      burst(16'h1235, "R4 after nop");
      burst(16'h1236, "R6 after undefined");
   endtask

   task automatic t_undef();
      pn = 0;
      put(0, 16'h0000, 8'h00);
      do_reset();
      burst(16'h0000, "R6 op00");
      burst(16'h0001, "R6 opFF");
      burst(16'h0002, "R6 opFF");
   endtask

   task automatic t_wrap();
      pn = 0;
      put(0, 16'h0000, 8'h7E);
      put(1, 16'h0001, 8'hFF);
      put(2, 16'h0002, 8'hFF);
      put(3, 16'hFFFF, 8'h01);
      do_reset();
      burst(16'h0000, "R9 jmp top");
      burst(16'hFFFF, "R9 wrap burst");
      burst(16'h0000, "R9 wrap pc");
   endtask

   task automatic t_halt_fetch();
      load_loop();
      do_reset();
      chk("R8 pre strobe", 32'(mem_rd), 32'd1);
      chk("R8 pre addr", 32'(mem_addr), 32'd0);
      step();
      halt = 1'b1;
      #1;
      for (int k = 0; k < 4; k++) begin
         chk("R8 halted strobe", 32'(mem_rd), 32'd0);
         chk("R8 halted addr", 32'(mem_addr), 32'd1);
         step();
      end
      halt = 1'b0;
      #1;
      chk("R8 resume strobe", 32'(mem_rd), 32'd1);
      chk("R8 resume addr", 32'(mem_addr), 32'd1);
      step();
      chk("R8 resume strobe", 32'(mem_rd), 32'd1);
      chk("R8 resume addr", 32'(mem_addr), 32'd2);
      step();
      gap(1 + EW, "R8 resume");
      burst(16'h0001, "R3 R8 opcode kept across halt");
      burst(16'h0000, "R3 R8 target kept across halt");
   endtask

   task automatic t_halt_wait();
      load_loop();
      do_reset();
      fetch3(16'h0000, "R8 wait");
      gap(3, "R8 before halt");
      halt = 1'b1;
      #1;
      for (int k = 0; k < 4; k++) begin
         chk("R8 wait halted strobe", 32'(mem_rd), 32'd0);
         chk("R8 R7 wait halted addr", 32'(mem_addr), 32'd0);
         step();
      end
      halt = 1'b0;
      gap(1 + EW - 3, "R8 after halt");
      burst(16'h0001, "R8 delayed burst");
   endtask

   task automatic t_reset_mid();
      load_loop();
      do_reset();
      fetch3(16'h0000, "R1 pre");
      gap(2, "R1 pre");
      step();
      rst = 1'b1;
      step();
      chk("R1 mid reset strobe", 32'(mem_rd), 32'd0);
      chk("R1 mid reset addr", 32'(mem_addr), 32'd0);
      rst = 1'b0;
      step();
      burst(16'h0000, "R1 restart");
      burst(16'h0001, "R1 restart");
   endtask

   initial begin
      rst = 1'b1;
      step();
      chk("R1 power-up strobe", 32'(mem_rd), 32'd0);
      t_loop();
      t_far();
      t_undef();
      t_wrap();
      t_halt_fetch();
      t_halt_wait();
      t_reset_mid();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule